// File: doc/BRIEF.md
# Exclusive Access Monitor Table

This block keeps the reservation state that a memory controller needs to answer exclusive (load-linked / store-conditional style) accesses from several bus masters. It watches one request descriptor per clock: a master ID, a byte address, a direction bit and an exclusive flag. From these it decides whether each exclusive write may go ahead. It also returns the response code the controller should send back, together with a commit flag that tells the controller whether the write may reach memory.

All masters share a single table of reservations. An exclusive read records its master and address granule. Any write that reaches memory removes every reservation on its granule, whichever master issued it. An exclusive write passes only if its own master still holds a reservation on that granule. When every slot is in use, a new reservation displaces a slot chosen by a free-running pseudo-random sequence.

Top module: `excl_monitor`

## Requirements
- R1: After reset, resp_valid is 0 and the table is empty, so the first exclusive write returns OKAY (2'b00) with resp_commit 0.
- R2: Each request accepted with req_valid high gives exactly one response, with resp_valid high on the clock edge after it. A cycle without a request gives resp_valid 0.
- R3: An exclusive read (req_write 0, req_excl 1) records its master ID and address granule and returns EXOKAY (2'b01) with resp_commit 1.
- R4: An exclusive write whose master holds a reservation on the same granule returns EXOKAY with resp_commit 1 and consumes that reservation, so an identical second exclusive write fails.
- R5: An exclusive write with no matching reservation (no entry, another master's entry, or another granule) returns OKAY with resp_commit 0 and leaves the table unchanged.
- R6: Every committed write clears all reservations on its granule, from any master. This covers plain writes and passing exclusive writes.
- R7: Addresses are compared on bits [ADDR_W-1:6], a 64-byte granule. Two byte addresses in the same granule match, and adjacent granules do not.
- R8: A second exclusive read by a master that already holds a reservation moves that reservation to the new granule instead of taking another slot.
- R9: While a slot is free, a new reservation goes into a free slot. Sixteen masters can then all hold reservations at once.
- R10: With all 16 slots in use, a reservation by a new master replaces exactly one existing slot. The slot is picked by a 4-bit LFSR (x^4+x^3+1, seed 1) that advances every cycle. The new master's exclusive write then passes and exactly one displaced master's write fails.
- R11: Non-exclusive reads return OKAY with resp_commit 1 and leave the table unchanged. Non-exclusive writes return OKAY with resp_commit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request descriptor present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_excl | input | 1 | Exclusive access flag |
| req_id | input | ID_W | Master ID |
| req_addr | input | ADDR_W | Byte address |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_code | output | 2 | 2'b00 OKAY, 2'b01 EXOKAY |
| resp_commit | output | 1 | 0 = write must not be committed |

## Verification
The bench sends exclusive writes that almost match: the wrong master, the neighbouring granule, and another byte of the right granule. A monitor that compares the ID loosely or masks the wrong address bits would pass the first two or fail the third. It checks that a plain write from a third master kills two reservations at once. A design that clears only the writer's own entry would let a stale store-conditional succeed. It fills all sixteen slots and then adds a seventeenth master. A repeat read that takes a new slot, an allocator that evicts while slots are free, or a replacement that drops none or several entries would change how many of the old masters still pass.

// File: rtl/excl_pkg.sv
package excl_pkg;
   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_EXOKAY = 2'b01
   } resp_e;

   // Feedback tap mask for a maximal-length shift-left Fibonacci LFSR
   function automatic logic [7:0] lfsr_taps(input int w);
      case (w)
         2:       return 8'h03;
         3:       return 8'h06;
         4:       return 8'h0C;
         5:       return 8'h14;
         default: return 8'h60;
      endcase
   endfunction
endpackage

// File: rtl/excl_lfsr.sv
module excl_lfsr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);
   localparam logic [7:0] TAPS = excl_pkg::lfsr_taps(W);

   logic fb;
   always_comb fb = ^(state & TAPS[W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) state <= W'(1);
      else        state <= {state[W-2:0], fb};
   end
endmodule

// File: rtl/excl_entry.sv
module excl_entry #(
   parameter int ID_W  = 5,
   parameter int TAG_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set,
   input  logic             clr,
   input  logic [ID_W-1:0]  lk_id,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             used,
   output logic             id_hit,
   output logic             tag_hit
);
   logic [ID_W-1:0]  own_id;
   logic [TAG_W-1:0] own_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used    <= 1'b0;
         own_id  <= '0;
         own_tag <= '0;
      end else if (set) begin
         used    <= 1'b1;
         own_id  <= lk_id;
         own_tag <= lk_tag;
      end else if (clr) begin
         used    <= 1'b0;
      end
   end

   always_comb begin
      id_hit  = used && (own_id == lk_id);
      tag_hit = used && (own_tag == lk_tag);
   end
endmodule

// File: rtl/excl_pick.sv
module excl_pick #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] used,
   input  logic [DEPTH-1:0] id_hit,
   input  logic [IDX_W-1:0] victim,
   output logic [IDX_W-1:0] slot
);
   logic             have_id, have_free;
   logic [IDX_W-1:0] id_idx, free_idx;

   always_comb begin
      have_id   = 1'b0;
      have_free = 1'b0;
      id_idx    = '0;
      free_idx  = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (id_hit[i]) begin
            have_id = 1'b1;
            id_idx  = IDX_W'(i);
         end
         if (!used[i]) begin
            have_free = 1'b1;
            free_idx  = IDX_W'(i);
         end
      end
      if (have_id)        slot = id_idx;
      else if (have_free) slot = free_idx;
      else                slot = victim;
   end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
   parameter int ID_W     = 5,
   parameter int ADDR_W   = 32,
   parameter int DEPTH    = 16,
   parameter int GRAN_LSB = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_excl,
   input  logic [ID_W-1:0]   req_id,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              resp_valid,
   output logic [1:0]        resp_code,
   output logic              resp_commit
);
   import excl_pkg::*;

   localparam int IDX_W = $clog2(DEPTH);
   localparam int TAG_W = ADDR_W - GRAN_LSB;

   if (DEPTH < 4 || DEPTH > 32 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two from 4 to 32");
   end
   if (GRAN_LSB >= ADDR_W) begin : g_bad_gran
      $error("GRAN_LSB must be below ADDR_W");
   end

   logic [TAG_W-1:0] tag;
   logic [DEPTH-1:0] used, id_hit, tag_hit, set, clr;
   logic [IDX_W-1:0] victim, slot;
   logic             rd_x, wr, wr_x, pass, commit_wr;

   always_comb begin
      tag       = req_addr[ADDR_W-1:GRAN_LSB];
      rd_x      = req_valid && !req_write && req_excl;
      wr        = req_valid && req_write;
      wr_x      = wr && req_excl;
      pass      = |(id_hit & tag_hit);
      commit_wr = wr && (!req_excl || pass);
   end

   excl_lfsr #(.W(IDX_W)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .state(victim)
   );

   excl_pick #(.DEPTH(DEPTH)) u_pick (
      .used(used), .id_hit(id_hit), .victim(victim), .slot(slot)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_comb begin
         set[i] = rd_x && (slot == IDX_W'(i));
         clr[i] = commit_wr && tag_hit[i];
      end
      excl_entry #(.ID_W(ID_W), .TAG_W(TAG_W)) u_entry (
         .clk(clk), .rst_n(rst_n), .set(set[i]), .clr(clr[i]),
         .lk_id(req_id), .lk_tag(tag),
         .used(used[i]), .id_hit(id_hit[i]), .tag_hit(tag_hit[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid  <= 1'b0;
         resp_code   <= RESP_OKAY;
         resp_commit <= 1'b0;
      end else begin
         resp_valid  <= req_valid;
         resp_code   <= (rd_x || (wr_x && pass)) ? RESP_EXOKAY : RESP_OKAY;
         resp_commit <= req_valid && !(wr_x && !pass);
      end
   end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
   parameter int ID_W   = 5,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic              req_excl,
   input logic [ID_W-1:0]   req_id,
   input logic [ADDR_W-1:0] req_addr,
   input logic              resp_valid,
   input logic [1:0]        resp_code,
   input logic              resp_commit
);
   logic live;
   always_ff @(posedge clk) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   // R2: a request is answered on the next edge
   a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      live && req_valid |=> resp_valid);
   // R2: no request, no response
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      live && !req_valid |=> !resp_valid);
   // R4 and R5: an exclusive write commits exactly when it reports EXOKAY
   a_r5_fail_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
      live && req_valid && req_write && req_excl |=>
         (resp_commit == (resp_code == 2'b01)));
   // R11: non-exclusive accesses get OKAY and commit
   a_r11_plain_okay: assert property (@(posedge clk) disable iff (!rst_n)
      live && req_valid && !req_excl |=> resp_code == 2'b00 && resp_commit);
   // R3: an exclusive read always gets EXOKAY
   a_r3_read_exokay: assert property (@(posedge clk) disable iff (!rst_n)
      live && req_valid && !req_write && req_excl |=> resp_code == 2'b01);
   // R1: reset output state
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> !resp_valid);
endmodule

bind excl_monitor excl_monitor_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_excl(req_excl), .req_id(req_id), .req_addr(req_addr),
   .resp_valid(resp_valid), .resp_code(resp_code), .resp_commit(resp_commit)
);

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
   localparam int ID_W = 5, ADDR_W = 32;
   localparam logic [1:0] OK = 2'b00, EX = 2'b01;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_excl = 1'b0;
   logic [ID_W-1:0]   req_id = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic resp_valid, resp_commit;
   logic [1:0] resp_code;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   excl_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_excl(req_excl), .req_id(req_id), .req_addr(req_addr),
      .resp_valid(resp_valid), .resp_code(resp_code), .resp_commit(resp_commit)
   );

   task automatic check(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   // Called at a falling edge; returns response sampled at the next falling edge
   task automatic send(input bit w, input bit x, input int id, input int addr,
                       output logic [1:0] code, output logic cm);
      req_valid = 1; req_write = w; req_excl = x;
      req_id = ID_W'(id); req_addr = ADDR_W'(addr);
      @(negedge clk);
      req_valid = 0;
      check("R2 resp_valid", int'(resp_valid), 1);
      code = resp_code; cm = resp_commit;
   endtask

   task automatic expect_req(input string rq, input bit w, input bit x, input int id,
                             input int addr, input logic [1:0] ec, input bit ecm);
      logic [1:0] c; logic m;
      send(w, x, id, addr, c, m);
      check({rq, " code"}, int'(c), int'(ec));
      check({rq, " commit"}, int'(m), int'(ecm));
   endtask

   task automatic do_reset();
      rst_n = 0; req_valid = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 resp_valid after reset", int'(resp_valid), 0);
      expect_req("R1 empty table", 1, 1, 0, 'h1000, OK, 0);
   endtask

   task automatic t_basic();
      expect_req("R3 excl read", 0, 1, 1, 'h2000, EX, 1);
      expect_req("R4 R7 same granule pass", 1, 1, 1, 'h2008, EX, 1);
      expect_req("R4 consumed", 1, 1, 1, 'h2000, OK, 0);
      @(negedge clk);
      check("R2 idle no resp", int'(resp_valid), 0);
   endtask

   task automatic t_mismatch();
      expect_req("R3 read id2", 0, 1, 2, 'h3000, EX, 1);
      expect_req("R5 other master", 1, 1, 3, 'h3000, OK, 0);
      expect_req("R7 next granule", 1, 1, 2, 'h3040, OK, 0);
      expect_req("R5 table unchanged", 1, 1, 2, 'h303F, EX, 1);
   endtask

   task automatic t_clear();
      expect_req("R3 read id4", 0, 1, 4, 'h4000, EX, 1);
      expect_req("R3 read id5", 0, 1, 5, 'h4010, EX, 1);
      expect_req("R11 plain write", 1, 0, 6, 'h4020, OK, 1);
      expect_req("R6 id4 cleared", 1, 1, 4, 'h4000, OK, 0);
      expect_req("R6 id5 cleared", 1, 1, 5, 'h4000, OK, 0);
      expect_req("R3 read id4 b", 0, 1, 4, 'h5000, EX, 1);
      expect_req("R3 read id5 b", 0, 1, 5, 'h5000, EX, 1);
      expect_req("R6 id4 passes", 1, 1, 4, 'h5000, EX, 1);
      expect_req("R6 id5 cleared by excl", 1, 1, 5, 'h5000, OK, 0);
   endtask

   task automatic t_plain_read();
      expect_req("R3 read id7", 0, 1, 7, 'h6000, EX, 1);
      expect_req("R11 plain read", 0, 0, 8, 'h6000, OK, 1);
      expect_req("R11 plain read kept entry", 1, 1, 7, 'h6000, EX, 1);
   endtask

   task automatic t_repeat();
      expect_req("R8 read F", 0, 1, 9, 'h7000, EX, 1);
      expect_req("R8 read G", 0, 1, 9, 'h7400, EX, 1);
      expect_req("R8 old address gone", 1, 1, 9, 'h7000, OK, 0);
      expect_req("R8 new address held", 1, 1, 9, 'h7400, EX, 1);
   endtask

   task automatic t_fill();
      logic [1:0] c; logic m;
      int passes;
      do_reset();
      for (int k = 0; k < 16; k++) send(0, 1, k, 'h10000 + k * 64, c, m);
      passes = 0;
      for (int k = 0; k < 16; k++) begin
         send(1, 1, k, 'h10000 + k * 64, c, m);
         if (c == EX && m) passes++;
      end
      check("R9 sixteen reservations held", passes, 16);
      for (int k = 0; k < 16; k++) send(0, 1, k, 'h20000 + k * 64, c, m);
      send(0, 1, 16, 'h30000, c, m);
      passes = 0;
      for (int k = 0; k < 16; k++) begin
         send(1, 1, k, 'h20000 + k * 64, c, m);
         if (c == EX && m) passes++;
      end
      check("R10 exactly one evicted", passes, 15);
      expect_req("R10 newcomer holds slot", 1, 1, 16, 'h30000, EX, 1);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_basic();
      t_mismatch();
      t_clear();
      t_plain_read();
      t_repeat();
      t_fill();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule